// File: doc/BRIEF.md
# Supply Voltage Monitor Control Register

This block is the digital side of a supply monitor. One 16-bit register holds an enable, a 4-bit threshold code, an interrupt enable and a sticky interrupt flag. A read-only ready bit rises only after the monitor has been enabled for a programmable number of clock cycles. The threshold code goes straight out to an external analog comparator. The selected level is 2.7 V plus 0.1 V for each code step. The comparator's "supply below threshold" answer comes back on an asynchronous input. That input passes through a two-flop synchronizer and is ignored until the monitor reports ready.

Software reaches the register through a plain port. A write strobe loads the 16-bit word on the rising clock edge, and the read data always shows the current register image. The port has no handshake: every strobe is accepted in the cycle it is seen, and the port never back-pressures.

Two rules protect the analog side. The threshold field cannot be changed while the monitor is running. The interrupt flag cannot be cleared while the supply is still low, because hardware sets it again in the same cycle.

Top module: `svmon_ctrl`

## Requirements
- R1: After reset, all register bits read 0, `irq` is 0 and `thresh_code` is 0.
- R2: Bit 0 is the monitor enable and bit 2 is the interrupt enable. A write loads both, and a read returns them.
- R3: A write loads bits 11:8 into the threshold field only if the enable bit was 0 before that write edge. Otherwise the field keeps its old value.
- R4: `thresh_code` always equals the threshold field shown in read bits 11:8.
- R5: The flag (bit 3) is set whenever the monitor is ready and the synchronized comparator reports low. This hardware set takes priority over a software write of 0 in the same cycle. Otherwise a write loads bit 3, and the flag holds between writes.
- R6: `irq` is 1 exactly when the flag and the interrupt enable are both 1, whether hardware or software set the flag.
- R7: Ready (bit 1) reads 1 from SETTLE_CYCLES clock edges after the edge that wrote enable = 1. It reads 0 in the same cycle the enable reads 0, and writes to bit 1 have no effect.
- R8: Bits 15:12 and 7:4 always read 0, whatever was written to them.
- R9: The comparator input takes effect two clock edges after it changes. Until ready is 1, the input cannot set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Word written on a strobed edge |
| rd_data | output | 16 | Current register image |
| below_async | input | 1 | Comparator result, 1 = supply below threshold, asynchronous |
| thresh_code | output | 4 | Threshold code sent to the comparator |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that SETTLE_CYCLES is at least 1. They also assume that the comparator input may toggle on any cycle, because the synchronizer absorbs it. The write strobe and data are assumed to be stable around the rising edge. The stimulus therefore drives every input on the falling edge, holds it for a full cycle, and places no limit on how often the comparator input toggles. Directed phases cover the lock, priority and settling corners. A pseudo-random phase then mixes writes, including ones to reserved bits, with arbitrary comparator toggling.

// File: rtl/svmon_pkg.sv
package svmon_pkg;
  localparam int REG_W    = 16;
  localparam int THR_W    = 4;
  localparam int POS_EN   = 0;
  localparam int POS_RDY  = 1;
  localparam int POS_IE   = 2;
  localparam int POS_FLAG = 3;
  localparam int POS_THR  = 8;

  typedef struct packed {
    logic             en;
    logic             ie;
    logic             flag;
    logic [THR_W-1:0] thr;
  } svmon_regs_t;

  function automatic logic [REG_W-1:0] pack_image(svmon_regs_t r, logic rdy);
    logic [REG_W-1:0] img;
    img                           = '0;
    img[POS_EN]                   = r.en;
    img[POS_RDY]                  = rdy;
    img[POS_IE]                   = r.ie;
    img[POS_FLAG]                 = r.flag;
    img[POS_THR +: THR_W]         = r.thr;
    return img;
  endfunction
endpackage

// File: rtl/svmon_sync.sv
module svmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/svmon_settle.sv
module svmon_settle #(
  parameter int SETTLE_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = en_i && (cnt_q == LIMIT);

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  assert_ready_after_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(en_i));
endmodule

// File: rtl/svmon_flag.sv
module svmon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_wr,
  input  logic sw_val,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hw_set) flag_q <= 1'b1;
    else if (sw_wr)  flag_q <= sw_val;
  end

  assign flag_o = flag_q;

  assert_hw_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_o);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !sw_wr) |=> flag_o);
endmodule

// File: rtl/svmon_ctrl.sv
module svmon_ctrl
  import svmon_pkg::*;
#(
  parameter int SETTLE_CYCLES = 5000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              below_async,
  output logic [THR_W-1:0]  thresh_code,
  output logic              irq
);
  svmon_regs_t regs_q;
  logic        ready;
  logic        below_sync;
  logic        flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q.en  <= 1'b0;
      regs_q.ie  <= 1'b0;
      regs_q.thr <= '0;
    end else if (wr_en) begin
      regs_q.en <= wr_data[POS_EN];
      regs_q.ie <= wr_data[POS_IE];
      if (!regs_q.en) regs_q.thr <= wr_data[POS_THR +: THR_W];
    end
  end

  svmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(below_async), .d_sync(below_sync)
  );

  svmon_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .en_i(regs_q.en), .ready_o(ready)
  );

  svmon_flag u_flag (
    .clk(clk), .rst_n(rst_n),
    .hw_set(ready && below_sync),
    .sw_wr(wr_en), .sw_val(wr_data[POS_FLAG]),
    .flag_o(flag)
  );

  // The flag register lives in u_flag, so the copy held here is unused.
  svmon_regs_t image_src;
  always_comb begin
    image_src      = regs_q;
    image_src.flag = flag;
  end

  assign rd_data     = pack_image(image_src, ready);
  assign thresh_code = regs_q.thr;
  assign irq         = flag && regs_q.ie;

  assert_thr_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q.en |=> $stable(thresh_code));
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[POS_FLAG] && rd_data[POS_IE]));
  assert_low_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[POS_RDY] && below_sync) |=> rd_data[POS_FLAG]);
endmodule

// File: tb/svmon_ctrl_test.sv
module svmon_ctrl_test;
  localparam int S = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        below_async = 1'b0;
  logic [15:0] rd_data;
  logic [3:0]  thresh_code;
  logic        irq;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit checking = 1'b0;

  always #2 clk = ~clk;

  svmon_ctrl #(.SETTLE_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .below_async(below_async),
    .thresh_code(thresh_code), .irq(irq)
  );

  // reference model state
  bit m_en, m_ie, m_flag;
  int m_thr, m_cnt;
  bit hist[$] = '{0, 0};

  function automatic bit m_ready();
    return m_en && (m_cnt == S);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_flag = 0; m_thr = 0; m_cnt = 0;
      hist = '{0, 0};
    end else begin
      bit hw;
      bit old_en;
      hw = m_ready() && hist[0];
      old_en = m_en;
      if (hw)         m_flag = 1;
      else if (wr_en) m_flag = wr_data[3];
      if (!old_en) m_cnt = 0;
      else if (m_cnt < S) m_cnt++;
      if (wr_en) begin
        if (!old_en) m_thr = int'(wr_data[11:8]);
        m_en = wr_data[0];
        m_ie = wr_data[2];
      end
      void'(hist.pop_front());
      hist.push_back(below_async);
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      cmp("R2 enable bit0", int'(rd_data[0]), int'(m_en));
      cmp("R2 ie bit2", int'(rd_data[2]), int'(m_ie));
      cmp("R3 threshold 11:8", int'(rd_data[11:8]), m_thr);
      cmp("R4 thresh_code", int'(thresh_code), int'(rd_data[11:8]));
      cmp("R5/R9 flag bit3", int'(rd_data[3]), int'(m_flag));
      cmp("R6 irq", int'(irq), int'(m_flag && m_ie));
      cmp("R7 ready bit1", int'(rd_data[1]), int'(m_ready()));
      cmp("R8 reserved", int'({rd_data[15:12], rd_data[7:4]}), 0);
    end
    if (cycles > 200000) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: reset image
    cmp("R1 reset rd_data", int'(rd_data), 0);
    cmp("R1 reset irq", int'(irq), 0);
    cmp("R1 reset thresh_code", int'(thresh_code), 0);
    @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;
    idle(2);
    wr(16'h0A00);                 // R3: thr loads while disabled
    wr(16'h0501);                 // thr 5 and enable in one write
    wr(16'h0C05);                 // R3: locked, thr stays 5
    below_async = 1'b1;           // R9: ignored before ready
    idle(S + 6);                  // R7: ready rises, then flag sets
    wr(16'h0005);                 // R5: clear while low is overridden
    below_async = 1'b0;
    idle(4);
    wr(16'h0005);                 // R5: clear now succeeds
    idle(2);
    wr(16'h0009);                 // R6: software set, ie 0
    wr(16'h000D);                 // R6: ie 1, irq rises
    wr(16'h0000);                 // R7: disable drops ready
    below_async = 1'b1;
    idle(6);                      // R9: no set while disabled
    wr(16'hFFF2);                 // R8, R7: reserved and ready writes ignored
    wr(16'h0001);
    idle(S / 2);
    wr(16'h0000);                 // disable mid-settle
    wr(16'h0001);
    idle(S + 4);
    below_async = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      below_async = ($urandom_range(0, 7) == 0) ? ~below_async : below_async;
      wr_en = ($urandom_range(0, 9) == 0);
      wr_data = 16'($urandom);
    end
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule